// File: doc/BRIEF.md
# Morse letter flasher

This block flashes the Morse code of one of eight letters, A to H, on a single LED output. A 3-bit letter select and a one-cycle start strobe come in. When start arrives while the block is idle, it captures the select and looks up that letter's dot/dash pattern. It then plays the pattern one element at a time. After a trailing pause it goes back to idle. A `busy` output stays high from the cycle after the accepted start until the trailing pause ends.

All timing is counted in units. One unit is `CYC_PER_UNIT` clock cycles. The default of 25,000,000 gives half a second on a 50 MHz clock. A divider makes a one-cycle enable pulse once per unit, and the sequencer advances only on that pulse. The divider is held at zero while the block is idle, so every letter starts on a fresh unit boundary. Dot, dash, gap and trailing pause lengths are parameters given in units.

The sequencer has four states:
- `ST_IDLE`: waits for start.
- `ST_MARK`: LED on for the current element.
- `ST_SPACE`: LED off between elements.
- `ST_TAIL`: LED off after the last element.

The transitions are:
- `accept`: `ST_IDLE` to `ST_MARK` on start.
- `mark_done`: `ST_MARK` to `ST_SPACE` when the element time has expired and more elements remain.
- `last_done`: `ST_MARK` to `ST_TAIL` when the element time has expired and it was the final element.
- `space_done`: `ST_SPACE` to `ST_MARK` on the next element.
- `tail_done`: `ST_TAIL` to `ST_IDLE`.

Top module: `morse_flasher`

## Requirements
- R1: A synchronous active-high `rst` puts the block in idle with `led` = 0 and `busy` = 0, including when it is asserted in the middle of a letter. After release the block stays idle until a start arrives.
- R2: A `start` sampled high while `busy` = 0 is accepted at that clock edge. From the next cycle `busy` = 1 and `led` = 1, because every letter begins with an element.
- R3: `letter_sel` encodes letters in binary order: 0 = A (dot dash), 1 = B (dash dot dot dot), 2 = C (dash dot dash dot), 3 = D (dash dot dot), 4 = E (dot), 5 = F (dot dot dash dot), 6 = G (dash dash dot), 7 = H (dot dot dot dot). Internally each pattern is four bits, played from bit 0 upward, with 1 meaning dot and 0 meaning dash, together with a length of 1 to 4 elements.
- R4: A dot keeps `led` high for `DOT_UNITS` (default 1) units. A dash keeps it high for `DASH_UNITS` (default 3) units. One unit is `CYC_PER_UNIT` cycles.
- R5: Between two elements of one letter, `led` is low for `GAP_UNITS` (default 1) units while `busy` stays high.
- R6: After the last element, `led` stays low for `TAIL_UNITS` (default 3) units with `busy` high. Then `busy` drops and the block is idle.
- R7: `start` pulses while `busy` = 1 are ignored. The letter in progress keeps its exact waveform, and no second letter follows it.
- R8: `letter_sel` is captured only when a start is accepted. Changing it while busy does not alter the letter being played.
- R9: The unit divider is held cleared while idle, so the first element always lasts a full unit, however long the block was idle before the start.
- R10: `led` is never high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| letter_sel | input | 3 | Letter index, 0 = A through 7 = H |
| start | input | 1 | Start request, sampled on the rising edge |
| led | output | 1 | LED drive, high while an element is shown |
| busy | output | 1 | High while a letter, including its trailing pause, is playing |

## Verification
The assertions take the following for granted:
- `start` and `letter_sel` are synchronous to `clk`.
- `letter_sel` is valid in the cycle where a start is accepted.
- Reset is applied from time zero.

Under these conditions, every lit run must measure exactly a dot or a dash in cycles, and every dark run inside a letter must measure exactly one gap. The stimulus changes inputs only on falling clock edges, so nothing changes at the sampling edge. It uses a small unit length so that every letter can be played to the end with different idle delays. Disturbing starts and select changes are injected only while the block is busy, or immediately after a letter has ended.

// File: rtl/morse_pkg.sv
package morse_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MARK,
        ST_SPACE,
        ST_TAIL
    } seq_state_t;

    // bits: element kinds played from bit 0 upward, 1 = dot, 0 = dash
    // last: element count minus one
    typedef struct packed {
        logic [3:0] bits;
        logic [1:0] last;
    } glyph_t;

    function automatic glyph_t glyph_of(input logic [2:0] sel);
        glyph_t g;
        unique case (sel)
            3'd0: g = '{bits: 4'b0001, last: 2'd1}; // A
            3'd1: g = '{bits: 4'b1110, last: 2'd3}; // B
            3'd2: g = '{bits: 4'b1010, last: 2'd3}; // C
            3'd3: g = '{bits: 4'b0110, last: 2'd2}; // D
            3'd4: g = '{bits: 4'b0001, last: 2'd0}; // E
            3'd5: g = '{bits: 4'b1011, last: 2'd3}; // F
            3'd6: g = '{bits: 4'b0100, last: 2'd2}; // G
            3'd7: g = '{bits: 4'b1111, last: 2'd3}; // H
            default: g = '{bits: 4'b0000, last: 2'd0};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/morse_unit_timer.sv
module morse_unit_timer #(
    parameter int unsigned CYC_PER_UNIT = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic tick
);
    localparam int unsigned CW = (CYC_PER_UNIT > 1) ? $clog2(CYC_PER_UNIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_UNIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = !hold && (cnt == LAST);

endmodule

// File: rtl/morse_glyph_rom.sv
module morse_glyph_rom
    import morse_pkg::*;
(
    input  logic [2:0] sel,
    output glyph_t     glyph
);
    always_comb begin
        glyph = glyph_of(sel);
    end
endmodule

// File: rtl/morse_sequencer.sv
module morse_sequencer
    import morse_pkg::*;
#(
    parameter int unsigned DOT_UNITS  = 1,
    parameter int unsigned DASH_UNITS = 3,
    parameter int unsigned GAP_UNITS  = 1,
    parameter int unsigned TAIL_UNITS = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  glyph_t glyph_in,
    input  logic   tick,
    output logic   led,
    output logic   busy,
    output logic   timer_hold
);
    localparam int unsigned MAX_A = (DOT_UNITS > DASH_UNITS) ? DOT_UNITS : DASH_UNITS;
    localparam int unsigned MAX_B = (GAP_UNITS > TAIL_UNITS) ? GAP_UNITS : TAIL_UNITS;
    localparam int unsigned MAXU  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned UW    = (MAXU > 1) ? $clog2(MAXU) : 1;

    localparam logic [UW-1:0] DOT_END  = UW'(DOT_UNITS - 1);
    localparam logic [UW-1:0] DASH_END = UW'(DASH_UNITS - 1);
    localparam logic [UW-1:0] GAP_END  = UW'(GAP_UNITS - 1);
    localparam logic [UW-1:0] TAIL_END = UW'(TAIL_UNITS - 1);

    seq_state_t    state;
    logic [3:0]    pat;
    logic [1:0]    last;
    logic [1:0]    idx;
    logic [UW-1:0] units;
    logic [UW-1:0] mark_end;

    always_comb begin
        mark_end = pat[idx] ? DOT_END : DASH_END;
    end

    // state register and element bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pat   <= '0;
            last  <= '0;
            idx   <= '0;
            units <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin            // accept
                        pat   <= glyph_in.bits;
                        last  <= glyph_in.last;
                        idx   <= '0;
                        units <= '0;
                        state <= ST_MARK;
                    end
                end
                ST_MARK: begin
                    if (tick) begin
                        if (units == mark_end) begin
                            units <= '0;
                            state <= (idx == last) ? ST_TAIL : ST_SPACE; // last_done / mark_done
                        end else begin
                            units <= units + UW'(1);
                        end
                    end
                end
                ST_SPACE: begin
                    if (tick) begin
                        if (units == GAP_END) begin     // space_done
                            units <= '0;
                            idx   <= idx + 2'd1;
                            state <= ST_MARK;
                        end else begin
                            units <= units + UW'(1);
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        if (units == TAIL_END) begin    // tail_done
                            units <= '0;
                            state <= ST_IDLE;
                        end else begin
                            units <= units + UW'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        led        = (state == ST_MARK);
        busy       = (state != ST_IDLE);
        timer_hold = (state == ST_IDLE);
    end

endmodule

// File: rtl/morse_flasher.sv
module morse_flasher
    import morse_pkg::*;
#(
    parameter int unsigned CYC_PER_UNIT = 25_000_000,
    parameter int unsigned DOT_UNITS    = 1,
    parameter int unsigned DASH_UNITS   = 3,
    parameter int unsigned GAP_UNITS    = 1,
    parameter int unsigned TAIL_UNITS   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] letter_sel,
    input  logic       start,
    output logic       led,
    output logic       busy
);
    glyph_t glyph;
    logic   unit_tick;
    logic   timer_hold;

    morse_glyph_rom u_rom (
        .sel   (letter_sel),
        .glyph (glyph)
    );

    morse_unit_timer #(
        .CYC_PER_UNIT (CYC_PER_UNIT)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .hold (timer_hold),
        .tick (unit_tick)
    );

    morse_sequencer #(
        .DOT_UNITS  (DOT_UNITS),
        .DASH_UNITS (DASH_UNITS),
        .GAP_UNITS  (GAP_UNITS),
        .TAIL_UNITS (TAIL_UNITS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .glyph_in   (glyph),
        .tick       (unit_tick),
        .led        (led),
        .busy       (busy),
        .timer_hold (timer_hold)
    );

endmodule

// File: rtl/morse_flasher_chk.sv
module morse_flasher_chk #(
    parameter int unsigned CYC_PER_UNIT = 25_000_000,
    parameter int unsigned DOT_UNITS    = 1,
    parameter int unsigned DASH_UNITS   = 3,
    parameter int unsigned GAP_UNITS    = 1
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic led,
    input logic busy,
    input logic tick
);
    localparam logic [31:0] DOT_CYC  = 32'(DOT_UNITS * CYC_PER_UNIT);
    localparam logic [31:0] DASH_CYC = 32'(DASH_UNITS * CYC_PER_UNIT);
    localparam logic [31:0] GAP_CYC  = 32'(GAP_UNITS * CYC_PER_UNIT);

    logic [31:0] on_run;
    logic [31:0] off_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_run  <= '0;
            off_run <= '0;
        end else begin
            on_run  <= led ? on_run + 32'd1 : 32'd0;
            off_run <= (busy && !led) ? off_run + 32'd1 : 32'd0;
        end
    end

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && led));

    // R10
    idle_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> (!led && !busy));

    // R4
    mark_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(led) |-> (on_run == DOT_CYC || on_run == DASH_CYC));

    // R5
    gap_length_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(led) && $past(busy)) |-> (off_run == GAP_CYC));

    // R6
    busy_drop_dark_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !$past(led));

    // R9
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tick);

endmodule

bind morse_flasher morse_flasher_chk #(
    .CYC_PER_UNIT (CYC_PER_UNIT),
    .DOT_UNITS    (DOT_UNITS),
    .DASH_UNITS   (DASH_UNITS),
    .GAP_UNITS    (GAP_UNITS)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .led   (led),
    .busy  (busy),
    .tick  (unit_tick)
);

// File: tb/test_morse_flasher.sv
module test_morse_flasher;
    localparam int C    = 4;
    localparam int DOTU = 1;
    localparam int DASU = 3;
    localparam int GAPU = 1;
    localparam int TAIU = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] letter_sel = 3'd0;
    logic       start = 1'b0;
    logic       led;
    logic       busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    morse_flasher #(
        .CYC_PER_UNIT (C),
        .DOT_UNITS    (DOTU),
        .DASH_UNITS   (DASU),
        .GAP_UNITS    (GAPU),
        .TAIL_UNITS   (TAIU)
    ) i_morse_flasher (
        .clk        (clk),
        .rst        (rst),
        .letter_sel (letter_sel),
        .start      (start),
        .led        (led),
        .busy       (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R3: letter code, '.' dot, '_' dash
    function automatic string code_of(input int sel);
        case (sel)
            0: return "._";
            1: return "_...";
            2: return "_._.";
            3: return "_..";
            4: return ".";
            5: return ".._.";
            6: return "__.";
            default: return "....";
        endcase
    endfunction

    // plays one letter, checking led and busy every cycle; a start pulse
    // with a different select is injected at cycle 'disturb' (R7, R8)
    task automatic run_letter(input int sel, input int idle_wait, input int disturb);
        bit    q[$];
        string s;
        s = code_of(sel);
        for (int k = 0; k < s.len(); k++) begin
            int on_u;
            on_u = (s[k] == "." ) ? DOTU : DASU;
            for (int c = 0; c < on_u * C; c++) q.push_back(1'b1);
            if (k != s.len() - 1)
                for (int c = 0; c < GAPU * C; c++) q.push_back(1'b0);
        end
        for (int c = 0; c < TAIU * C; c++) q.push_back(1'b0);

        for (int w = 0; w < idle_wait; w++) begin
            @(negedge clk);
            chk(led == 1'b0, "R10 idle led", led, 0);   // R10
        end
        letter_sel = 3'(sel);
        start = 1'b1;
        @(negedge clk);
        for (int i = 0; i < q.size(); i++) begin
            chk(led == q[i], $sformatf("R3/R4/R5/R9 letter %0d cycle %0d led", sel, i), led, q[i]);
            chk(busy == 1'b1, $sformatf("R2/R6 letter %0d cycle %0d busy", sel, i), busy, 1);
            start = (i == disturb);                       // R7
            if (i == disturb) letter_sel = ~3'(sel);      // R8
            @(negedge clk);
        end
        start = 1'b0;
        chk(busy == 1'b0, $sformatf("R6 letter %0d busy after tail", sel), busy, 0);
        chk(led == 1'b0, $sformatf("R6 letter %0d led after tail", sel), led, 0);
        @(negedge clk);
        chk(busy == 1'b0, $sformatf("R7 letter %0d no restart", sel), busy, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(led == 1'b0, "R1 reset led", led, 0);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 idle after release", busy, 0);

        // sweep every letter with two idle delays and two disturb points
        for (int sel = 0; sel < 8; sel++) begin
            run_letter(sel, 1, 2 + sel);
            run_letter(sel, 6 + sel, 0);
        end
        // back-to-back with no idle gap (R9)
        run_letter(1, 0, 5);

        // R1: reset in the middle of a letter
        letter_sel = 3'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk(led == 1'b1 || led == 1'b0, "R1 mid-letter pre", led, led);
        rst = 1'b1;
        @(negedge clk);
        chk(led == 1'b0, "R1 mid reset led", led, 0);
        chk(busy == 1'b0, "R1 mid reset busy", busy, 0);
        rst = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(busy == 1'b0 && led == 1'b0, "R1 stays idle after reset", busy, 0);
        end
        // block still works after reset
        run_letter(4, 2, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule